// File: doc/BRIEF.md
# CB-Group Shift and Bit Unit

This execution unit handles the second-page opcode group of an 8-bit accumulator CPU. That group covers eight rotate and shift modes plus test, clear and set of a single bit. On each cycle with `in_valid` high it takes an opcode byte, an operand byte and the current carry flag. One clock later it presents a registered result. Alongside the result it gives a write-back enable for the operand location, a flag-register write enable, a full flag byte and the instruction's cycle count.

The opcode byte is split into three fields. Bits [7:6] pick the operation group. Bits [5:3] pick either the shift mode or the bit index. Bits [2:0] name the operand location, and code 6 is the memory operand at the address held in the pointer pair. The unit never reads or writes registers or memory itself. The surrounding datapath fetches the operand and uses `wb_en` and `flag_wr` to decide what to commit. The cycle count is the one for an unindexed opcode.

Top module: `cb_shift_bit_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid`, `wb_en`, `flag_wr`, `result`, `flags` and `cycles` are all zero.
- R2: An input accepted with `in_valid` high appears on the outputs after exactly one rising clock edge, with `out_valid` high. After a cycle with `in_valid` low, `out_valid` is low and every other output holds its previous value.
- R3: The opcode is decoded as group = opcode[7:6] (0 shift/rotate, 1 bit test, 2 bit clear, 3 bit set), sel = opcode[5:3] and loc = opcode[2:0]. loc 6 is the memory operand.
- R4: In group 0 with sel 0..3, the result is: sel 0, rotate left with bit 7 also going to bit 0; sel 1, rotate right with bit 0 also going to bit 7; sel 2, rotate left through carry; sel 3, rotate right through carry. The bit shifted out becomes the new carry.
- R5: In group 0 with sel 4..7, the result is: sel 4, shift left filling 0; sel 5, shift right keeping bit 7; sel 6, shift left filling 1; sel 7, shift right filling 0. The bit shifted out becomes the new carry.
- R6: Group 0 raises `wb_en` and `flag_wr`. S is result bit 7, Z is set when the result is zero, P/V is 1 for even parity of the result, and H and N are 0.
- R7: Group 1 gives `wb_en`=0 and `flag_wr`=1 and returns the operand unchanged. Z is the inverse of operand bit sel, P/V equals Z, H=1, N=0, C is the incoming carry, and S is 1 only when sel is 7 and the bit is set.
- R8: Group 2 returns the operand with bit sel cleared. It gives `wb_en`=1 and `flag_wr`=0, and the flag byte is zero except C, which equals the incoming carry.
- R9: Group 3 returns the operand with bit sel set. Its enables and flag byte are the same as in R8.
- R10: `cycles` is 8 when loc is not 6. When loc is 6 it is 12 for group 1 and 15 for every other group.
- R11: The flag byte places S at bit 7, Z at bit 6, H at bit 4, P/V at bit 2, N at bit 1 and C at bit 0. Bits 5 and 3 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Opcode, operand and carry are valid this cycle |
| opcode | input | 8 | Second-page opcode byte |
| operand | input | 8 | Operand value fetched by the datapath |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered outputs belong to a new operation |
| result | output | 8 | Value to write back to the operand location |
| wb_en | output | 1 | Result must be written back |
| flag_wr | output | 1 | Flag byte must be written to the flag register |
| flags | output | 8 | Updated flag byte (layout in R11) |
| cycles | output | 5 | Cycle count of the decoded opcode |

## Verification
There is only one register stage, so a wrong decode shows up on the very next cycle. If the group is misread, the wrong `wb_en` or `flag_wr` appears on that cycle. If the bit index or shift mode is misread, `result` or the carry bit is wrong on that cycle. A fault in the output capture logic shows up as `out_valid` failing to drop, or as outputs that do not hold across an idle cycle. Random vectors over every opcode and operand are compared against a reference model. Directed vectors pin down the carry-through rotates, the sign-keeping shift, the fill-with-one shift and bit-7 testing.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
  localparam int FLAG_W  = 8;
  localparam int FLG_S   = 7;
  localparam int FLG_Z   = 6;
  localparam int FLG_H   = 4;
  localparam int FLG_PV  = 2;
  localparam int FLG_N   = 1;
  localparam int FLG_C   = 0;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLEAR = 2'd2,
    GRP_SETB  = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SH_ROLC = 3'd0,
    SH_RORC = 3'd1,
    SH_ROLT = 3'd2,
    SH_RORT = 3'd3,
    SH_SHLZ = 3'd4,
    SH_SHRA = 3'd5,
    SH_SHLO = 3'd6,
    SH_SHRL = 3'd7
  } shmode_e;

  typedef struct packed {
    logic s;
    logic z;
    logic h;
    logic pv;
    logic n;
    logic c;
  } flagset_t;

  function automatic logic [FLAG_W-1:0] pack_flags(input flagset_t f);
    logic [FLAG_W-1:0] b;
    b         = '0;
    b[FLG_S]  = f.s;
    b[FLG_Z]  = f.z;
    b[FLG_H]  = f.h;
    b[FLG_PV] = f.pv;
    b[FLG_N]  = f.n;
    b[FLG_C]  = f.c;
    return b;
  endfunction
endpackage

// File: rtl/cbx_decode.sv
module cbx_decode
  import cbx_pkg::*;
#(
  parameter int OPC_W    = 8,
  parameter int IDX_W    = 3,
  parameter int LOC_W    = 3,
  parameter int MEM_CODE = 6
) (
  input  logic [OPC_W-1:0] opcode,
  output grp_e             grp,
  output shmode_e          mode,
  output logic [IDX_W-1:0] bit_idx,
  output logic             mem_opnd
);
  localparam int SEL_LO = LOC_W;
  localparam int GRP_LO = LOC_W + IDX_W;

  logic [LOC_W-1:0] loc;

  always_comb begin
    grp      = grp_e'(opcode[OPC_W-1:GRP_LO]);
    bit_idx  = opcode[GRP_LO-1:SEL_LO];
    mode     = shmode_e'(opcode[GRP_LO-1:SEL_LO]);
    loc      = opcode[LOC_W-1:0];
    mem_opnd = (loc == LOC_W'(MEM_CODE));
  end
endmodule

// File: rtl/cbx_rotator.sv
module cbx_rotator
  import cbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  input  shmode_e           mode,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    res  = a;
    cout = cin;
    unique case (mode)
      SH_ROLC: begin res = {a[MSB-1:0], a[MSB]}; cout = a[MSB]; end
      SH_RORC: begin res = {a[0], a[MSB:1]};     cout = a[0];   end
      SH_ROLT: begin res = {a[MSB-1:0], cin};    cout = a[MSB]; end
      SH_RORT: begin res = {cin, a[MSB:1]};      cout = a[0];   end
      SH_SHLZ: begin res = {a[MSB-1:0], 1'b0};   cout = a[MSB]; end
      SH_SHRA: begin res = {a[MSB], a[MSB:1]};   cout = a[0];   end
      SH_SHLO: begin res = {a[MSB-1:0], 1'b1};   cout = a[MSB]; end
      SH_SHRL: begin res = {1'b0, a[MSB:1]};     cout = a[0];   end
      default: begin res = a;                    cout = cin;    end
    endcase
  end
endmodule

// File: rtl/cbx_bitop.sv
module cbx_bitop
  import cbx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [IDX_W-1:0]  idx,
  input  grp_e              grp,
  output logic [DATA_W-1:0] res,
  output logic              tested
);
  logic fill;
  assign fill   = (grp == GRP_SETB);
  assign tested = a[idx];

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    logic hit;
    assign hit    = (idx == IDX_W'(i));
    assign res[i] = hit ? fill : a[i];
  end
endmodule

// File: rtl/cb_shift_bit_unit.sv
module cb_shift_bit_unit
  import cbx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int OPC_W        = 8,
  parameter int CYC_W        = 5,
  parameter int CYC_REG      = 8,
  parameter int CYC_MEM      = 15,
  parameter int CYC_MEM_TEST = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              wb_en,
  output logic              flag_wr,
  output logic [FLAG_W-1:0] flags,
  output logic [CYC_W-1:0]  cycles
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int LOC_W = OPC_W - 2 - IDX_W;

  grp_e              grp;
  shmode_e           mode;
  logic [IDX_W-1:0]  bit_idx;
  logic              mem_opnd;
  logic [DATA_W-1:0] rot_res;
  logic              rot_c;
  logic [DATA_W-1:0] bop_res;
  logic              tested;

  logic [DATA_W-1:0] n_res;
  logic              n_wb;
  logic              n_fw;
  flagset_t          n_fl;
  logic [CYC_W-1:0]  n_cyc;

  cbx_decode #(.OPC_W(OPC_W), .IDX_W(IDX_W), .LOC_W(LOC_W), .MEM_CODE(6)) u_dec (
    .opcode(opcode), .grp(grp), .mode(mode), .bit_idx(bit_idx), .mem_opnd(mem_opnd)
  );

  cbx_rotator #(.DATA_W(DATA_W)) u_rot (
    .a(operand), .cin(carry_in), .mode(mode), .res(rot_res), .cout(rot_c)
  );

  cbx_bitop #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bop (
    .a(operand), .idx(bit_idx), .grp(grp), .res(bop_res), .tested(tested)
  );

  always_comb begin
    n_res = operand;
    n_wb  = 1'b0;
    n_fw  = 1'b0;
    n_fl  = '{s: 1'b0, z: 1'b0, h: 1'b0, pv: 1'b0, n: 1'b0, c: carry_in};
    unique case (grp)
      GRP_SHIFT: begin
        n_res = rot_res;
        n_wb  = 1'b1;
        n_fw  = 1'b1;
        n_fl  = '{s: rot_res[DATA_W-1], z: ~|rot_res, h: 1'b0,
                  pv: ~^rot_res, n: 1'b0, c: rot_c};
      end
      GRP_TEST: begin
        n_res = operand;
        n_wb  = 1'b0;
        n_fw  = 1'b1;
        n_fl  = '{s: tested & (bit_idx == IDX_W'(DATA_W-1)), z: ~tested,
                  h: 1'b1, pv: ~tested, n: 1'b0, c: carry_in};
      end
      default: begin
        n_res = bop_res;
        n_wb  = 1'b1;
        n_fw  = 1'b0;
      end
    endcase
    if (!mem_opnd)             n_cyc = CYC_W'(CYC_REG);
    else if (grp == GRP_TEST)  n_cyc = CYC_W'(CYC_MEM_TEST);
    else                       n_cyc = CYC_W'(CYC_MEM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      wb_en     <= 1'b0;
      flag_wr   <= 1'b0;
      flags     <= '0;
      cycles    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= n_res;
        wb_en   <= n_wb;
        flag_wr <= n_fw;
        flags   <= pack_flags(n_fl);
        cycles  <= n_cyc;
      end
    end
  end

  AST_VALID_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid)); // R2

  AST_TEST_NO_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    in_valid && opcode[OPC_W-1 -: 2] == 2'b01 |=> out_valid && !wb_en && flag_wr
      && result == $past(operand)); // R7

  AST_BITOP_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    in_valid && opcode[OPC_W-1] |=> !flag_wr && wb_en
      && ($countones(result ^ $past(operand)) <= 1)); // R8

  AST_SHIFT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    out_valid && wb_en && flag_wr |-> !flags[FLG_H] && !flags[FLG_N]
      && (flags[FLG_Z] == (result == '0))); // R6

  AST_CYCLE_SET: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> cycles == CYC_W'(CYC_REG) || cycles == CYC_W'(CYC_MEM)
      || cycles == CYC_W'(CYC_MEM_TEST)); // R10

  AST_FLAG_GAPS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !flags[5] && !flags[3]); // R11
endmodule

// File: tb/tb_cb_shift_bit_unit.sv
module tb_cb_shift_bit_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [7:0] opcode;
  logic [7:0] operand;
  logic       carry_in;
  logic       out_valid;
  logic [7:0] result;
  logic       wb_en;
  logic       flag_wr;
  logic [7:0] flags;
  logic [4:0] cycles;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cb_shift_bit_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .operand(operand),
    .carry_in(carry_in), .out_valid(out_valid), .result(result), .wb_en(wb_en),
    .flag_wr(flag_wr), .flags(flags), .cycles(cycles)
  );

  // Reference model written from the requirements.
  function automatic void model(input logic [7:0] op, input logic [7:0] a, input logic cin,
                                output logic [7:0] r, output logic wb, output logic fw,
                                output logic [7:0] f, output logic [4:0] cy);
    logic [2:0] sel;
    logic       c;
    logic       bt;
    sel = op[5:3];
    f   = 8'h00;
    cy  = (op[2:0] != 3'd6) ? 5'd8 : ((op[7:6] == 2'd1) ? 5'd12 : 5'd15);
    case (op[7:6])
      2'd0: begin
        case (sel)
          3'd0: begin r = {a[6:0], a[7]}; c = a[7]; end
          3'd1: begin r = {a[0], a[7:1]}; c = a[0]; end
          3'd2: begin r = {a[6:0], cin};  c = a[7]; end
          3'd3: begin r = {cin, a[7:1]};  c = a[0]; end
          3'd4: begin r = {a[6:0], 1'b0}; c = a[7]; end
          3'd5: begin r = {a[7], a[7:1]}; c = a[0]; end
          3'd6: begin r = {a[6:0], 1'b1}; c = a[7]; end
          default: begin r = {1'b0, a[7:1]}; c = a[0]; end
        endcase
        wb = 1'b1; fw = 1'b1;
        f[7] = r[7]; f[6] = (r == 8'h00); f[2] = ~^r; f[0] = c;
      end
      2'd1: begin
        bt = a[sel];
        r = a; wb = 1'b0; fw = 1'b1;
        f[7] = bt && sel == 3'd7; f[6] = ~bt; f[4] = 1'b1; f[2] = ~bt; f[0] = cin;
      end
      2'd2: begin
        r = a & ~(8'h01 << sel); wb = 1'b1; fw = 1'b0; f[0] = cin;
      end
      default: begin
        r = a | (8'h01 << sel); wb = 1'b1; fw = 1'b0; f[0] = cin;
      end
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string group_tag(input logic [7:0] op);
    case (op[7:6])
      2'd0: return (op[5:3] < 3'd4) ? "R4" : "R5";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Drive at falling edge; outputs are sampled at the next falling edge (one register).
  task automatic apply(input logic [7:0] op, input logic [7:0] a, input logic cin);
    logic [7:0] er, ef;
    logic       ewb, efw;
    logic [4:0] ecy;
    model(op, a, cin, er, ewb, efw, ef, ecy);
    in_valid = 1'b1; opcode = op; operand = a; carry_in = cin;
    @(negedge clk);
    vectors++;
    check("R2 out_valid", 16'(out_valid), 16'd1);
    check($sformatf("%s result op=%0h", group_tag(op), op), 16'(result), 16'(er));
    check($sformatf("%s wb_en op=%0h", group_tag(op), op), 16'(wb_en), 16'(ewb));
    check($sformatf("%s flag_wr op=%0h", group_tag(op), op), 16'(flag_wr), 16'(efw));
    check($sformatf("%s flags op=%0h", (op[7:6] == 2'd0) ? "R6" : group_tag(op), op),
          16'(flags), 16'(ef));
    check($sformatf("R10 cycles op=%0h", op), 16'(cycles), 16'(ecy));
    check("R11 flag gaps", 16'(flags & 8'h28), 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] held_r;
    logic [7:0] held_f;
    void'($urandom(32'h5EED_00C8));
    rst = 1'b1; in_valid = 1'b0; opcode = 8'h00; operand = 8'h00; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    vectors++;
    // R1 reset state
    check("R1 out_valid", 16'(out_valid), 16'd0);
    check("R1 result", 16'(result), 16'd0);
    check("R1 wb_en", 16'(wb_en), 16'd0);
    check("R1 flag_wr", 16'(flag_wr), 16'd0);
    check("R1 flags", 16'(flags), 16'd0);
    check("R1 cycles", 16'(cycles), 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 16'(out_valid), 16'd0);

    // R4 directed: left rotate with wrap of 0x80, carry 0 in -> 0x01, flags C=1
    apply(8'h00, 8'h80, 1'b0);
    check("R4 rotl wrap", 16'({result, flags}), 16'h0101);
    // R4 right rotate through carry of 0x01, carry 0 -> 0x00, Z,PV,C set
    apply(8'h18, 8'h01, 1'b0);
    check("R4 rotr thru carry", 16'({result, flags}), 16'h0045);
    apply(8'h10, 8'h80, 1'b1);   // R4 left through carry
    // R5 sign-keeping shift 0x81 -> 0xC0, C=1, S=1, even parity
    apply(8'h2F, 8'h81, 1'b0);
    check("R5 shra keep sign", 16'({result, flags}), 16'hC085);
    apply(8'h37, 8'h00, 1'b0);   // R5 shift left filling one
    check("R5 shlo fill", 16'(result), 16'h0001);
    apply(8'h3F, 8'h80, 1'b1);   // R5 logical right
    // R7 bit test on memory operand, bit 7 set: S=1, H=1, cycles 12 (R3 field split)
    apply(8'h7E, 8'h80, 1'b1);
    check("R7 test bit7", 16'({flags, 3'b000, cycles}), {8'h91, 8'h0C});
    apply(8'h46, 8'hFE, 1'b0);   // R7 bit 0 clear -> Z, PV
    apply(8'h86, 8'hFF, 1'b1);   // R8 clear bit 0, memory, 15 cycles
    check("R8 clear bit0", 16'(result), 16'h00FE);
    apply(8'hFF, 8'h00, 1'b0);   // R9 set bit 7 register A
    check("R9 set bit7", 16'(result), 16'h0080);
    apply(8'hC6, 8'h00, 1'b0);   // R10 set in memory form

    // R2 idle cycle: out_valid drops, outputs hold
    held_r = result; held_f = flags;
    in_valid = 1'b0; opcode = 8'h00; operand = 8'h55;
    @(negedge clk);
    vectors++;
    check("R2 idle out_valid", 16'(out_valid), 16'd0);
    check("R2 idle hold", 16'({result, flags}), 16'({held_r, held_f}));

    for (int i = 0; i < 256; i++) apply(8'(i), 8'($urandom), 1'($urandom));
    for (int i = 0; i < 3000; i++) begin
      apply(8'($urandom), 8'($urandom), 1'($urandom));
      if (($urandom % 8) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 gap", 16'(out_valid), 16'd0);
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule